// File: doc/BRIEF.md
# Prescaled Digital Input Pulse Filter

This block cleans up slow asynchronous input pins before other logic uses them. It has a set of channel inputs and one external-clock pin input. Each input first passes through a two-flop synchronizer. It is then sampled on a filter tick, which a prescaler derives from the system clock. A filtered level changes only after two consecutive tick samples agree on a new value, so any shorter glitch is discarded. Every change of a filtered level also produces a one-cycle rise or fall strobe.

A three-bit divide code sets the tick period to 4, 8, 16, 32 or 64 system clocks. This sets the shortest pulse the filter is sure to pass. A separate select sets the filter for the external-clock pin. That pin can use the same programmable tick as the channels, or a fixed four-clock tick. Both settings are captured in the first clock cycle after reset is released, and they hold until the next reset.

Top module: `pinflt_top`

## Requirements
- R1: The captured divide code 000, 001, 010, 011 or 100 makes the channel filter tick repeat every 4, 8, 16, 32 or 64 system clocks respectively.
- R2: Divide codes 101, 110 and 111 behave exactly like 100, a 64-clock tick.
- R3: During reset and right after it, every filtered level and every strobe is 0, and the captured divide code is 000.
- R4: With a tick period of P clocks, an input pulse of P clocks or less never changes the filtered level. A pulse of 2P clocks or more always produces exactly one rise and one fall.
- R5: A rise strobe is high for exactly the one cycle in which its level first reads 1. A fall strobe is high for exactly the one cycle in which its level first reads 0. The two strobes of one input are never high together.
- R6: When pin_share is 0, the clock-pin filter uses a fixed 4-clock tick. When pin_share is 1, it uses the channel tick.
- R7: div_code and pin_share are captured in the first cycle after reset is released. Later changes to either have no effect until the next reset.
- R8: A filtered level changes only in the cycle that follows a channel filter tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_code | input | 3 | Prescaler divide code, captured once after reset |
| pin_share | input | 1 | 1: clock pin uses channel tick; 0: fixed 4-clock tick |
| ch_in | input | N_CH | Asynchronous channel inputs |
| cpin_in | input | 1 | Asynchronous external-clock pin input |
| ch_lvl | output | N_CH | Filtered channel levels |
| ch_rise | output | N_CH | One-cycle rising-edge strobes |
| ch_fall | output | N_CH | One-cycle falling-edge strobes |
| cpin_lvl | output | 1 | Filtered clock-pin level |
| cpin_rise | output | 1 | Clock-pin rising-edge strobe |
| cpin_fall | output | 1 | Clock-pin falling-edge strobe |

## Verification
The bench builds the block with N_CH = 4 and the 64-clock ceiling on the divide ratio, which is the default. It drives every code from 000 to 111. Each code gets a pulse of exactly one tick period and a pulse of two tick periods, so the guaranteed-reject and guaranteed-pass edges of R4 are reached on every ratio, including the aliased codes. Four channels let the bench check that channel filters share one tick and stay independent of the clock-pin path. With the longest ratio, the fixed 4-clock clock-pin filter is plainly separated from the shared tick.

// File: rtl/pinflt_pkg.sv
// Package: shared constants and the code-to-terminal-count mapping
// for the prescaled pin filter. Assumes ratios are 4 << code, capped.
package pinflt_pkg;
    localparam int BASE_RATIO = 4;
    localparam int MAX_SHIFT  = 4;
    localparam int MAX_RATIO  = BASE_RATIO << MAX_SHIFT;
    localparam int CNT_W      = $clog2(MAX_RATIO);
    localparam int CODE_W     = 3;

    // Terminal count (ratio - 1) for a divide code; codes past MAX_SHIFT saturate.
    function automatic logic [CNT_W-1:0] term_of(input logic [CODE_W-1:0] code);
        int sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        return CNT_W'((BASE_RATIO << sh) - 1);
    endfunction
endpackage

// File: rtl/pinflt_presc.sv
// Prescaler: issues a programmable tick and a fixed 4-clock tick.
// Assumes code is stable (captured once after reset).
module pinflt_presc
    import pinflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              prog_tick,
    output logic              fix_tick
);
    localparam int FIX_W = $clog2(BASE_RATIO);

    logic [CNT_W-1:0] prog_cnt;
    logic [FIX_W-1:0] fix_cnt;
    logic [CNT_W-1:0] term;

    assign term      = term_of(code);
    assign prog_tick = (prog_cnt == term);
    assign fix_tick  = (fix_cnt == FIX_W'(BASE_RATIO - 1));

    // Programmable counter wraps at the selected terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)         prog_cnt <= '0;
        else if (prog_tick) prog_cnt <= '0;
        else                prog_cnt <= prog_cnt + 1'b1;
    end

    // Fixed counter wraps every BASE_RATIO clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) fix_cnt <= '0;
        else        fix_cnt <= fix_cnt + 1'b1;
    end
endmodule

// File: rtl/pinflt_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pinflt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pinflt_cell.sv
// One filter cell: samples a synchronized input on each tick and moves the
// level only when two consecutive samples agree on a new value.
// Assumes tick is a single-cycle pulse.
module pinflt_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic smp;
    logic take;

    assign take = tick && (din == smp) && (din != lvl);

    // Hold the previous tick sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    smp <= 1'b0;
        else if (tick) smp <= din;
    end

    // Update the level and emit one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl  <= 1'b0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            rise <= take && din;
            fall <= take && !din;
            if (take) lvl <= din;
        end
    end
endmodule

// File: rtl/pinflt_top.sv
// Top: captures configuration once after reset, synchronizes the inputs and
// filters N_CH channels plus one clock pin. Assumes synchronous reset.
module pinflt_top
    import pinflt_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    input  logic              pin_share,
    input  logic [N_CH-1:0]   ch_in,
    input  logic              cpin_in,
    output logic [N_CH-1:0]   ch_lvl,
    output logic [N_CH-1:0]   ch_rise,
    output logic [N_CH-1:0]   ch_fall,
    output logic              cpin_lvl,
    output logic              cpin_rise,
    output logic              cpin_fall
);
    localparam int NS = N_CH + 1;

    logic              cfg_done;
    logic [CODE_W-1:0] code_q;
    logic              share_q;
    logic              prog_tick;
    logic              fix_tick;
    logic              cpin_tick;
    logic [NS-1:0]     sync_q;

    // Capture configuration in the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_done <= 1'b0;
            code_q   <= '0;
            share_q  <= 1'b0;
        end else if (!cfg_done) begin
            cfg_done <= 1'b1;
            code_q   <= div_code;
            share_q  <= pin_share;
        end
    end

    pinflt_presc presc_i (
        .clk(clk), .rst_n(rst_n), .code(code_q),
        .prog_tick(prog_tick), .fix_tick(fix_tick)
    );

    pinflt_sync #(.W(NS)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({cpin_in, ch_in}), .q(sync_q)
    );

    assign cpin_tick = share_q ? prog_tick : fix_tick;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pinflt_cell cell_i (
            .clk(clk), .rst_n(rst_n), .tick(prog_tick), .din(sync_q[i]),
            .lvl(ch_lvl[i]), .rise(ch_rise[i]), .fall(ch_fall[i])
        );
    end

    pinflt_cell cpin_cell_i (
        .clk(clk), .rst_n(rst_n), .tick(cpin_tick), .din(sync_q[N_CH]),
        .lvl(cpin_lvl), .rise(cpin_rise), .fall(cpin_fall)
    );
endmodule

// File: rtl/pinflt_chk.sv
// Checker: temporal properties of pinflt_top, attached by bind below.
module pinflt_chk
    import pinflt_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CH-1:0]   ch_lvl,
    input logic [N_CH-1:0]   ch_rise,
    input logic [N_CH-1:0]   ch_fall,
    input logic              cpin_lvl,
    input logic              cpin_rise,
    input logic              cpin_fall,
    input logic              prog_tick,
    input logic              cfg_done,
    input logic [CODE_W-1:0] code_q
);
    a_r5_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_rise & ch_fall) == '0) && !(cpin_rise && cpin_fall));

    a_r5_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ch_rise == (ch_lvl & ~$past(ch_lvl)));

    a_r5_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ch_fall == (~ch_lvl & $past(ch_lvl)));

    a_r5_cpin_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (cpin_rise == (cpin_lvl && !$past(cpin_lvl))) &&
        (cpin_fall == (!cpin_lvl && $past(cpin_lvl))));

    a_r8_change_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_lvl != $past(ch_lvl)) |-> $past(prog_tick));

    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> $stable(code_q) && cfg_done);
endmodule

bind pinflt_top pinflt_chk #(.N_CH(N_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .ch_lvl(ch_lvl), .ch_rise(ch_rise),
    .ch_fall(ch_fall), .cpin_lvl(cpin_lvl), .cpin_rise(cpin_rise),
    .cpin_fall(cpin_fall), .prog_tick(prog_tick), .cfg_done(cfg_done),
    .code_q(code_q)
);

// File: tb/pinflt_top_tb.sv
// Directed bench for pinflt_top: one task per scenario.
module pinflt_top_tb_top;
    localparam int N_CH = 4;
    localparam int TCLK = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      div_code = 3'd0;
    logic            pin_share = 1'b0;
    logic [N_CH-1:0] ch_in = '0;
    logic            cpin_in = 1'b0;
    logic [N_CH-1:0] ch_lvl, ch_rise, ch_fall;
    logic            cpin_lvl, cpin_rise, cpin_fall;

    int total = 0;
    int bad = 0;
    int rise_n [N_CH+1];
    int fall_n [N_CH+1];
    logic clr = 1'b1;

    always #(TCLK/2) clk = ~clk;

    pinflt_top #(.N_CH(N_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .div_code(div_code), .pin_share(pin_share),
        .ch_in(ch_in), .cpin_in(cpin_in), .ch_lvl(ch_lvl), .ch_rise(ch_rise),
        .ch_fall(ch_fall), .cpin_lvl(cpin_lvl), .cpin_rise(cpin_rise),
        .cpin_fall(cpin_fall)
    );

    // Strobe counters, index N_CH is the clock pin.
    always @(posedge clk) begin
        for (int i = 0; i <= N_CH; i++) begin
            if (clr) begin
                rise_n[i] = 0;
                fall_n[i] = 0;
            end else begin
                rise_n[i] += int'((i == N_CH) ? cpin_rise : ch_rise[i]);
                fall_n[i] += int'((i == N_CH) ? cpin_fall : ch_fall[i]);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input int code);
        return 4 << ((code > 4) ? 4 : code);
    endfunction

    // Reset with a configuration; checks the reset state (R3).
    task automatic do_reset(input int code, input logic share);
        @(negedge clk);
        rst_n = 1'b0;
        div_code = 3'(code);
        pin_share = share;
        ch_in = '0;
        cpin_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 reset lvl", int'(ch_lvl) + int'(cpin_lvl), 0);
        check("R3 reset strobes",
              int'(ch_rise) + int'(ch_fall) + int'(cpin_rise) + int'(cpin_fall), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Drive one pulse on all inputs and count resulting edges.
    task automatic pulse(input int width, input int settle,
                         input int exp_ch, input int exp_cp, input string req);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        ch_in = '1;
        cpin_in = 1'b1;
        repeat (width) @(negedge clk);
        ch_in = '0;
        cpin_in = 1'b0;
        repeat (settle) @(negedge clk);
        for (int i = 0; i < N_CH; i++) begin
            check({req, " ch rise"}, rise_n[i], exp_ch);
            check({req, " ch fall"}, fall_n[i], exp_ch);
        end
        check({req, " cpin rise"}, rise_n[N_CH], exp_cp);
        check({req, " cpin fall"}, fall_n[N_CH], exp_cp);
        check({req, " ch idle lvl"}, int'(ch_lvl), 0);
    endtask

    // R1/R2/R4: one-period pulse rejected, two-period pulse passed, every code.
    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            int p;
            p = ratio(c);
            do_reset(c, 1'b1);
            pulse(p, 5 * p + 10, 0, 0, (c > 4) ? "R2 short" : "R1 R4 short");
            pulse(2 * p, 5 * p + 10, 1, 1, (c > 4) ? "R2 long" : "R1 R4 long");
        end
    endtask

    // R6: clock pin on the fixed 4-clock tick versus the shared tick.
    task automatic t_cpin();
        do_reset(4, 1'b0);
        pulse(8, 330, 0, 1, "R6 fixed");
        pulse(4, 330, 0, 0, "R6 fixed short");
        do_reset(4, 1'b1);
        pulse(8, 330, 0, 0, "R6 shared");
    endtask

    // R7: configuration changes after capture are ignored.
    task automatic t_latch();
        do_reset(4, 1'b1);
        div_code = 3'd0;
        pin_share = 1'b0;
        repeat (3) @(negedge clk);
        pulse(8, 330, 0, 0, "R7 ignored");
        pulse(128, 330, 1, 1, "R7 held ratio");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_codes();
        t_cpin();
        t_latch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule